// File: doc/BRIEF.md
# Cursor SRAM Image Loader

The loader copies a small hardware-cursor bitmap, 32 bits per pixel, into on-chip cursor SRAM. A load command supplies the image width, height and source row stride. Pixels then arrive on a valid/ready stream in row-major order. For each pixel inside the requested width, the loader swaps the red and blue bytes and issues one SRAM write strobe. The SRAM address follows a banked pattern rather than a linear count. The largest image is 64x32 or 32x64 pixels, which is 2048 words.

A separate command fills the 256-word transparency memory with a fixed pattern. A load command whose `cold` flag is set runs that fill first and then the image load. Software uses this after the cursor SRAM has been powered down, because both memories have lost their contents. The block signals completion with a single-cycle `done` pulse. It ignores any command while it is busy.

Top module: `cursor_img_loader`

## Requirements
- R1: During and directly after synchronous reset, `busy`, `done`, `sram_we` and `pix_ready` are all low.
- R2: Every image write carries the accepted pixel with byte lanes 0 (bits 7:0) and 2 (bits 23:16) exchanged, and lanes 1 and 3 unchanged.
- R3: The k-th image write of a load (k counted from 0) goes to address 0xC000 + 0x1000*(k/256) + (k mod 256) for k < 1024. Within each 256-word sub-bank the address rises by one per written pixel.
- R4: When the low 8 address bits roll over to zero, the address moves up by 0xF00 to the start of the next sub-bank (0xC0FF is followed by 0xD000).
- R5: When the address masked with 0x30FF becomes zero, the address reloads with the second region base 0x4000. For k >= 1024 the k-th write goes to 0x4000 + 0x1000*((k-1024)/256) + (k mod 256).
- R6: A fill command writes 0x55555555 to addresses 0x2000 through 0x20FF, one write per cycle on 256 consecutive cycles. The first write appears two cycles after the command is sampled.
- R7: A load command with `cold` set performs the full transparency fill before accepting any pixel. Its image writes then start again at address 0xC000.
- R8: Each row consumes max(stride, width) pixel beats. Only the first `width` beats of each row are written; the remaining beats are accepted and dropped.
- R9: `done` is high for exactly one cycle. For an image load it comes two cycles after the cycle in which the last pixel beat is accepted. For a fill-only job it comes the cycle after the last fill write.
- R10: A command seen while `busy` is high has no effect. When `start_img` and `start_fill` are both high in an idle cycle, only the image load runs.
- R11: A load command with zero width or zero height makes no image writes and accepts no pixels. It raises `done`, after the fill when `cold` is set; without `cold`, `done` comes two cycles after the command.
- R12: `pix_ready` is high only in the image phase. Each image write appears in the cycle right after the handshake of the pixel it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_img | input | 1 | Start an image load (sampled while idle) |
| start_fill | input | 1 | Start a transparency fill only |
| cold | input | 1 | With start_img: run the transparency fill first |
| width | input | 7 | Image width in pixels (0..64) |
| height | input | 7 | Image height in rows (0..64) |
| stride | input | 7 | Source beats per row (values below width act as width) |
| pix_valid | input | 1 | Pixel stream valid |
| pix_data | input | 32 | Pixel word |
| pix_ready | output | 1 | Pixel stream ready |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | 16 | SRAM write address |
| sram_wdata | output | 32 | SRAM write data |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs a full 2048-pixel load in both image shapes. This exercises the sub-bank jump at each 256-word boundary and the reload into the second region. A design that counted linearly, or forgot the reload, would write 0xC100 or 0x0000 where 0xD000 and 0x4000 are expected. Padded rows (stride above width) with gaps in the stream catch a loader that writes the padding or loses row alignment. Commands issued while busy, simultaneous commands and zero-size loads catch a design that restarts mid-job, runs a fill it should drop, or hangs waiting for pixels that never come.

// File: rtl/cil_pkg.sv
// Shared types for the cursor image loader.
// Assumes: nothing beyond the 1800-2017 language.
package cil_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_IMG  = 2'd2,
        ST_FIN  = 2'd3
    } ldr_state_e;
endpackage

// File: rtl/cil_swap.sv
// Byte-lane permutation: exchanges two chosen lanes, passes the others.
// Assumes: LANE_A and LANE_B are distinct and below LANES.
module cil_swap #(
    parameter int LANES  = 4,
    parameter int LANE_A = 0,
    parameter int LANE_B = 2,
    localparam int DW    = LANES * 8
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    // route each output lane from its source lane
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        localparam int SRC = (b == LANE_A) ? LANE_B : ((b == LANE_B) ? LANE_A : b);
        assign dout[b*8 +: 8] = din[SRC*8 +: 8];
    end
endmodule

// File: rtl/cil_addr.sv
// Banked write-address sequencer. It starts at BASE_A and steps one word per
// request. On a low-field rollover it jumps by JUMP. When the masked address
// is zero it reloads BASE_B.
// Assumes: BASE_A, BASE_B and JUMP have zero low fields.
module cil_addr #(
    parameter int             AW          = 16,
    parameter int             SUB_W       = 8,
    parameter logic [AW-1:0]  BASE_A      = 16'hC000,
    parameter logic [AW-1:0]  BASE_B      = 16'h4000,
    parameter logic [AW-1:0]  JUMP        = 16'h0F00,
    parameter logic [AW-1:0]  REGION_MASK = 16'h30FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] nxt;

    // next address: increment, sub-bank jump, region reload
    always_comb begin
        nxt = addr + AW'(1);
        if (nxt[SUB_W-1:0] == '0)
            nxt = nxt + JUMP;
        if ((nxt & REGION_MASK) == '0)
            nxt = BASE_B;
    end

    // address register
    always_ff @(posedge clk) begin
        if (!rst_n)      addr <= BASE_A;
        else if (init)   addr <= BASE_A;
        else if (step)   addr <= nxt;
    end

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init) |=> (addr[SUB_W-1:0] == $past(addr[SUB_W-1:0]) + SUB_W'(1)));
endmodule

// File: rtl/cil_ctrl.sv
// Job sequencer for the loader: accepts commands while idle, runs the
// transparency fill, walks rows and columns of the pixel stream, and flags
// the finish cycle.
// Assumes: stride below width is treated as width; sizes are pre-checked.
module cil_ctrl
    import cil_pkg::*;
#(
    parameter int DIM_W  = 7,
    parameter int FILL_N = 256,
    localparam int FILL_W = $clog2(FILL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_img,
    input  logic              start_fill,
    input  logic              cold,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    input  logic [DIM_W-1:0]  stride,
    input  logic              pix_valid,
    output logic              pix_ready,
    output logic              busy,
    output logic              fill_wr,
    output logic              img_wr,
    output logic [FILL_W-1:0] fill_idx,
    output logic              ag_init,
    output logic              fin
);
    ldr_state_e        st_q;
    logic [DIM_W-1:0]  w_q, h_q, s_q, col_q, row_q, row_len;
    logic [FILL_W-1:0] fcnt_q;
    logic              then_img_q;
    logic              zero_dim, hs, last_col, last_row, fill_last;

    // beats per source row
    always_comb row_len = (s_q < w_q) ? w_q : s_q;

    assign zero_dim  = (width == '0) || (height == '0);
    assign hs        = pix_valid && (st_q == ST_IMG);
    assign last_col  = (col_q == row_len - DIM_W'(1));
    assign last_row  = (row_q == h_q - DIM_W'(1));
    assign fill_last = (fcnt_q == FILL_W'(FILL_N - 1));

    assign pix_ready = (st_q == ST_IMG);
    assign busy      = (st_q != ST_IDLE);
    assign fill_wr   = (st_q == ST_FILL);
    assign img_wr    = hs && (col_q < w_q);
    assign fill_idx  = fcnt_q;
    assign ag_init   = (st_q == ST_IDLE) && start_img;
    assign fin       = (st_q == ST_FIN);

    // job state, latched geometry and position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            w_q        <= '0;
            h_q        <= '0;
            s_q        <= '0;
            col_q      <= '0;
            row_q      <= '0;
            fcnt_q     <= '0;
            then_img_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_img) begin
                        w_q        <= width;
                        h_q        <= height;
                        s_q        <= stride;
                        col_q      <= '0;
                        row_q      <= '0;
                        fcnt_q     <= '0;
                        then_img_q <= !zero_dim;
                        if (cold)          st_q <= ST_FILL;
                        else if (zero_dim) st_q <= ST_FIN;
                        else               st_q <= ST_IMG;
                    end else if (start_fill) begin
                        fcnt_q     <= '0;
                        then_img_q <= 1'b0;
                        st_q       <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    fcnt_q <= fcnt_q + FILL_W'(1);
                    if (fill_last)
                        st_q <= then_img_q ? ST_IMG : ST_FIN;
                end
                ST_IMG: begin
                    if (hs) begin
                        if (last_col) begin
                            col_q <= '0;
                            if (last_row) st_q  <= ST_FIN;
                            else          row_q <= row_q + DIM_W'(1);
                        end else begin
                            col_q <= col_q + DIM_W'(1);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(w_q) && $stable(h_q) && $stable(s_q)));

    // R6
    fill_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL && !fill_last) |=> (st_q == ST_FILL));
endmodule

// File: rtl/cursor_img_loader.sv
// Cursor SRAM image loader top. It registers one SRAM write per cycle from
// either the fill pattern or the byte-swapped pixel at the banked address,
// and registers the done pulse.
// Assumes: the SRAM accepts a write on every cycle that sram_we is high.
module cursor_img_loader #(
    parameter int            DIM_W       = 7,
    parameter int            AW          = 16,
    parameter int            FILL_N      = 256,
    parameter logic [AW-1:0] FILL_BASE   = 16'h2000,
    parameter logic [31:0]   FILL_WORD   = 32'h5555_5555,
    parameter logic [AW-1:0] IMG_BASE_A  = 16'hC000,
    parameter logic [AW-1:0] IMG_BASE_B  = 16'h4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_img,
    input  logic             start_fill,
    input  logic             cold,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic [DIM_W-1:0] stride,
    input  logic             pix_valid,
    input  logic [31:0]      pix_data,
    output logic             pix_ready,
    output logic             sram_we,
    output logic [AW-1:0]    sram_addr,
    output logic [31:0]      sram_wdata,
    output logic             busy,
    output logic             done
);
    localparam int FILL_W = $clog2(FILL_N);

    logic              fill_wr, img_wr, ag_init, fin, fill_q;
    logic [FILL_W-1:0] fill_idx;
    logic [AW-1:0]     img_addr;
    logic [31:0]       swapped;

    cil_ctrl #(.DIM_W(DIM_W), .FILL_N(FILL_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_img(start_img), .start_fill(start_fill),
        .cold(cold), .width(width), .height(height), .stride(stride),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .busy(busy),
        .fill_wr(fill_wr), .img_wr(img_wr), .fill_idx(fill_idx),
        .ag_init(ag_init), .fin(fin)
    );

    cil_addr #(.AW(AW), .BASE_A(IMG_BASE_A), .BASE_B(IMG_BASE_B)) u_addr (
        .clk(clk), .rst_n(rst_n), .init(ag_init), .step(img_wr), .addr(img_addr)
    );

    cil_swap #(.LANES(4), .LANE_A(0), .LANE_B(2)) u_swap (
        .din(pix_data), .dout(swapped)
    );

    // registered SRAM write port and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_we    <= 1'b0;
            sram_addr  <= '0;
            sram_wdata <= '0;
            fill_q     <= 1'b0;
            done       <= 1'b0;
        end else begin
            sram_we    <= fill_wr || img_wr;
            sram_addr  <= fill_wr ? (FILL_BASE + AW'(fill_idx)) : img_addr;
            sram_wdata <= fill_wr ? FILL_WORD : swapped;
            fill_q     <= fill_wr;
            done       <= fin;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && !fill_q) |->
            (sram_wdata[23:16] == $past(pix_data[7:0]) &&
             sram_wdata[7:0]   == $past(pix_data[23:16]) &&
             sram_wdata[31:24] == $past(pix_data[31:24]) &&
             sram_wdata[15:8]  == $past(pix_data[15:8])));

    // R12
    img_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && !fill_q) |-> $past(pix_valid && pix_ready));
endmodule

// File: tb/cursor_img_loader_tb.sv
`timescale 1ns/1ps
module cursor_img_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_img = 1'b0, start_fill = 1'b0, cold = 1'b0;
    logic [6:0]  width = '0, height = '0, stride = '0;
    logic        pix_valid = 1'b0;
    logic [31:0] pix_data = '0;
    logic        pix_ready, sram_we, busy, done;
    logic [15:0] sram_addr;
    logic [31:0] sram_wdata;

    int checks = 0, errors = 0, cyc = 0;
    logic [31:0] mem [int];

    // behavioural reference state
    int m_mode = 0, m_t = 0, m_col = 0, m_row = 0, m_k = 0;
    int m_w = 0, m_h = 0, m_s = 0;
    bit m_then = 0, m_pw = 0, m_dn = 0;
    int m_pa = 0;
    logic [31:0] m_pd = '0;
    string m_req = "R1";

    cursor_img_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start_img(start_img), .start_fill(start_fill),
        .cold(cold), .width(width), .height(height), .stride(stride),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .busy(busy), .done(done)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rb(input logic [31:0] d);
        return {d[31:24], d[7:0], d[15:8], d[23:16]};
    endfunction

    function automatic int exp_addr(input int k);
        if (k < 1024) return 'hC000 + 'h1000 * (k / 256) + (k % 256);
        return 'h4000 + 'h1000 * ((k - 1024) / 256) + (k % 256);
    endfunction

    function automatic logic [31:0] pix(input int seed, input int i);
        logic [31:0] v;
        v = 32'(i) * 32'h9E37_79B1;
        return v ^ 32'(seed);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the behavioural model, then model advance
    always @(negedge clk) begin
        int rl;
        if (sram_we) mem[int'(sram_addr)] = sram_wdata;
        if (!rst_n) m_req = "R1";
        chk(sram_we == m_pw, m_req, "sram_we", sram_we, m_pw);
        if (m_pw && sram_we) begin
            chk(int'(sram_addr) == m_pa, m_req, "sram_addr", sram_addr, m_pa);
            chk(sram_wdata == m_pd, m_req == "R6" ? "R6" : "R2", "sram_wdata", sram_wdata, m_pd);
        end
        chk(done == m_dn, !rst_n ? "R1" : "R9", "done", done, m_dn);
        chk(busy == (m_mode != 0), !rst_n ? "R1" : "R10", "busy", busy, m_mode != 0);
        chk(pix_ready == (m_mode == 2), !rst_n ? "R1" : "R12", "pix_ready", pix_ready, m_mode == 2);
        m_pw = 0;
        m_dn = 0;
        if (!rst_n) begin
            m_mode = 0;
        end else begin
            case (m_mode)
                0: if (start_img) begin
                        m_w = int'(width); m_h = int'(height); m_s = int'(stride);
                        m_col = 0; m_row = 0; m_k = 0; m_t = 0;
                        m_then = (m_w != 0 && m_h != 0);
                        if (cold) m_mode = 1;
                        else m_mode = m_then ? 2 : 3;
                    end else if (start_fill) begin
                        m_t = 0; m_then = 0; m_mode = 1;
                    end
                1: begin
                        m_pw = 1; m_pa = 'h2000 + m_t; m_pd = 32'h5555_5555; m_req = "R6";
                        m_t++;
                        if (m_t == 256) m_mode = m_then ? 2 : 3;
                    end
                2: if (pix_valid) begin
                        rl = (m_s < m_w) ? m_w : m_s;
                        if (m_col < m_w) begin
                            m_pw = 1; m_pa = exp_addr(m_k); m_pd = rb(pix_data);
                            m_req = (m_k >= 1024) ? "R5" : ((m_k >= 256) ? "R4" : "R3");
                            m_k++;
                        end
                        m_col++;
                        if (m_col == rl) begin
                            m_col = 0; m_row++;
                            if (m_row == m_h) m_mode = 3;
                        end
                    end
                default: begin m_dn = 1; m_mode = 0; end
            endcase
        end
    end

    task automatic kick(input bit img, input bit fil, input bit cld,
                        input int w, input int h, input int s);
        @(posedge clk); #1;
        start_img = img; start_fill = fil; cold = cld;
        width = 7'(w); height = 7'(h); stride = 7'(s);
        @(posedge clk); #1;
        start_img = 0; start_fill = 0; cold = 0;
    endtask

    task automatic stream(input int n, input int gap, input int seed);
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && (i % gap) == gap - 1) begin
                pix_valid = 0;
                @(posedge clk); #1;
            end
            pix_valid = 1;
            pix_data = pix(seed, i);
            forever begin
                @(negedge clk);
                if (pix_ready) break;
            end
            @(posedge clk); #1;
        end
        pix_valid = 0;
    endtask

    task automatic wait_done();
        forever begin
            @(negedge clk);
            if (done) break;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values seen at the ports
        chk(!busy && !done && !sram_we && !pix_ready, "R1", "reset outputs",
            {busy, done, sram_we, pix_ready}, 0);
        rst_n = 1;
        repeat (2) @(posedge clk); #1;

        // R6: fill only
        mem.delete();
        kick(1'b0, 1'b1, 1'b0, 0, 0, 0);
        wait_done();
        chk(mem.size() == 256, "R6", "fill word count", mem.size(), 256);
        chk(mem.exists('h20FF) && mem['h20FF] == 32'h5555_5555, "R6", "fill last",
            mem.exists('h20FF) ? mem['h20FF] : 0, 32'h5555_5555);

        // R3 R4 R5: full 64x32 image, no padding
        mem.delete();
        kick(1'b1, 1'b0, 1'b0, 64, 32, 64);
        stream(2048, 0, 32'h1234_5678);
        wait_done();
        chk(mem.size() == 2048, "R3", "image word count", mem.size(), 2048);
        chk(mem['hC0FF] == rb(pix(32'h1234_5678, 255)), "R3", "0xC0FF", mem['hC0FF], rb(pix(32'h1234_5678, 255)));
        chk(mem.exists('hD000) && mem['hD000] == rb(pix(32'h1234_5678, 256)), "R4", "0xD000",
            mem.exists('hD000) ? mem['hD000] : 0, rb(pix(32'h1234_5678, 256)));
        chk(mem.exists('h4000) && mem['h4000] == rb(pix(32'h1234_5678, 1024)), "R5", "0x4000",
            mem.exists('h4000) ? mem['h4000] : 0, rb(pix(32'h1234_5678, 1024)));
        chk(mem.exists('h70FF) && mem['h70FF] == rb(pix(32'h1234_5678, 2047)), "R5", "0x70FF",
            mem.exists('h70FF) ? mem['h70FF] : 0, rb(pix(32'h1234_5678, 2047)));

        // R7: cold 32x64 load with stream gaps
        mem.delete();
        kick(1'b1, 1'b0, 1'b1, 32, 64, 32);
        stream(2048, 7, 32'h0BAD_F00D);
        wait_done();
        chk(mem.size() == 2304, "R7", "fill plus image count", mem.size(), 2304);
        chk(mem['hC000] == rb(pix(32'h0BAD_F00D, 0)), "R7", "first image word", mem['hC000], rb(pix(32'h0BAD_F00D, 0)));
        chk(mem['h2000] == 32'h5555_5555, "R7", "fill word", mem['h2000], 32'h5555_5555);

        // R8: padded rows, 5 wide, stride 8, 3 rows
        mem.delete();
        kick(1'b1, 1'b0, 1'b0, 5, 3, 8);
        stream(24, 3, 32'h0F0F_1234);
        wait_done();
        chk(mem.size() == 15, "R8", "written words", mem.size(), 15);
        chk(mem['hC005] == rb(pix(32'h0F0F_1234, 8)), "R8", "row1 col0", mem['hC005], rb(pix(32'h0F0F_1234, 8)));
        chk(!mem.exists('hC00F), "R8", "no write past image", mem.exists('hC00F), 0);

        // R10: commands while busy are dropped
        mem.delete();
        kick(1'b1, 1'b0, 1'b0, 4, 2, 4);
        kick(1'b0, 1'b1, 1'b0, 0, 0, 0);
        kick(1'b1, 1'b0, 1'b1, 9, 9, 9);
        stream(8, 2, 32'h7777_0001);
        wait_done();
        chk(mem.size() == 8, "R10", "busy commands ignored", mem.size(), 8);
        chk(!mem.exists('h2000), "R10", "no fill while busy", mem.exists('h2000), 0);

        // R10: both commands at once, image wins
        mem.delete();
        kick(1'b1, 1'b1, 1'b0, 2, 1, 2);
        stream(2, 0, 32'h3131_3131);
        wait_done();
        chk(mem.size() == 2 && !mem.exists('h2000), "R10", "image priority", mem.size(), 2);

        // R11: zero width, no cold
        mem.delete();
        kick(1'b1, 1'b0, 1'b0, 0, 5, 4);
        wait_done();
        chk(mem.size() == 0, "R11", "zero width writes", mem.size(), 0);

        // R11: zero height with cold runs only the fill
        mem.delete();
        kick(1'b1, 1'b0, 1'b1, 6, 0, 6);
        wait_done();
        chk(mem.size() == 256, "R11", "zero height cold writes", mem.size(), 256);

        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule